// File: doc/BRIEF.md
# Compact Brainfuck execution core

This block is a small sequential processor that runs a fixed sixteen-entry program of compressed Brainfuck instructions against an eight-cell tape of bytes. Each instruction byte holds a 3-bit opcode in bits 7:5 and a 5-bit argument in bits 4:0. Pointer moves and cell arithmetic are therefore run-length compressed. The two bracket instructions carry a precomputed PC-relative offset, so the core never scans for the matching bracket. The program sits in a ROM with a registered output. The tape is a synchronous RAM with a one-cycle read latency. A binary-encoded controller steps every instruction through explicit fetch and memory wait states.

Byte input and output use a simple handshake to serial engines that sit outside the block. A pulse on the start input clears the tape and runs the program from address 0. A pulse on the halt input stops the core at once and returns it to idle. The busy flag, program counter, data pointer and current cell value are brought out for observation.

The built-in program is a case converter. It reads a byte and sets cell 1 to 10. For each nonzero input it subtracts 32 and outputs the result, then reads the next byte. When it reads 0x00 it leaves the loop, outputs cell 1 (a newline) and halts at address 13.

Top module: `bfc_core`

## Requirements
- R1: While reset is held and after its release, busy_o, pc_o, dp_o, cell_o, tx_valid_o and rx_ack_o are all zero, and the core waits in idle.
- R2: Opcodes are 000 pointer right, 001 pointer left, 010 add, 011 subtract, 100 output, 101 input, 110 jump if cell zero, and 111 jump if cell nonzero. The byte 0x00 is a halt instruction: it drops busy_o and leaves pc_o at its own address. The program therefore stops with pc_o = 13.
- R3: A start_i pulse seen in idle or halted state raises busy_o on the next cycle, with pc_o = 0, dp_o = 0 and every tape cell cleared to zero.
- R4: Fetching takes three cycles with pc_o held. A pointer move finishes in those three cycles. Add, subtract and jump take six cycles. The move argument is a signed 5-bit offset and the data pointer wraps modulo 8.
- R5: The output instruction holds tx_valid_o high, with tx_data_o equal to the current cell, until a clock edge at which tx_ready_i is high. The program counter then advances.
- R6: The input instruction waits for rx_valid_i, stores rx_data_i into the current cell, and pulses rx_ack_o for exactly one cycle in the cycle after acceptance.
- R7: A jump adds its signed 5-bit offset to pc_o when taken and adds 1 otherwise. The jump at address 4 (+6) goes to 10 on a zero cell. The jump at address 10 (-6) goes to 4 on a nonzero cell.
- R8: Add and subtract use the unsigned 5-bit argument and wrap modulo 256.
- R9: halt_i has priority over everything else. While it is high, tx_valid_o and rx_ack_o are held low and no tape write happens. The next cycle shows busy_o low with pc_o unchanged. A start_i in the same cycle is ignored.
- R10: With input bytes "abc" followed by 0x00, the output bytes are "ABC" followed by 0x0A.
- R11: cell_o shows the tape cell at the data pointer, one cycle after the pointer or the cell changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Clear tape and run from address 0 |
| halt_i | input | 1 | Stop immediately and return to idle |
| tx_ready_i | input | 1 | Output engine accepts the byte |
| rx_valid_i | input | 1 | Input engine holds a byte |
| rx_data_i | input | 8 | Received byte |
| tx_valid_o | output | 1 | Byte offered to the output engine |
| tx_data_o | output | 8 | Byte to transmit |
| rx_ack_o | output | 1 | Received byte consumed |
| busy_o | output | 1 | Program running |
| pc_o | output | 4 | Program counter |
| dp_o | output | 3 | Data pointer |
| cell_o | output | 8 | Cell at the data pointer |

## Verification
The collision that matters is a halt landing in the same cycle as an I/O handshake. The bench holds an output byte pending with tx_ready_i low. It then raises halt_i and tx_ready_i together for one cycle. It judges the result by tx_valid_o falling in that cycle, no byte being collected, and pc_o staying at the output instruction's address. Start and halt are also raised together in idle, and busy_o must stay low. All of this runs against a behavioural model that is compared on every clock.

// File: rtl/bfc_pkg.sv
package bfc_pkg;
  localparam int OP_W  = 3;
  localparam int ARG_W = 5;
  localparam int IW    = OP_W + ARG_W;

  typedef enum logic [OP_W-1:0] {
    OP_RIGHT = 3'd0,
    OP_LEFT  = 3'd1,
    OP_ADD   = 3'd2,
    OP_SUB   = 3'd3,
    OP_OUT   = 3'd4,
    OP_IN    = 3'd5,
    OP_JZ    = 3'd6,
    OP_JNZ   = 3'd7
  } op_e;

  typedef struct packed {
    op_e              op;
    logic [ARG_W-1:0] arg;
  } instr_t;

  typedef enum logic [3:0] {
    S_IDLE, S_FETCH, S_FWAIT, S_DECODE, S_MWAIT, S_EXEC,
    S_WRITE, S_TXW, S_RXW, S_JUMP, S_HALTED
  } state_e;
endpackage

// File: rtl/bfc_rom.sv
module bfc_rom #(
  parameter int PC_W = 4,
  parameter int IW   = 8
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [PC_W-1:0] addr_i,
  output logic [IW-1:0]   data_o
);
  function automatic logic [IW-1:0] prog(input logic [PC_W-1:0] a);
    case (int'(a))
      0:       prog = IW'(8'hA0); // in
      1:       prog = IW'(8'h01); // right 1
      2:       prog = IW'(8'h4A); // add 10
      3:       prog = IW'(8'h21); // left 1
      4:       prog = IW'(8'hC6); // jz +6
      5:       prog = IW'(8'h6F); // sub 15
      6:       prog = IW'(8'h6F); // sub 15
      7:       prog = IW'(8'h62); // sub 2
      8:       prog = IW'(8'h80); // out
      9:       prog = IW'(8'hA0); // in
      10:      prog = IW'(8'hFA); // jnz -6
      11:      prog = IW'(8'h01); // right 1
      12:      prog = IW'(8'h80); // out
      default: prog = '0;         // halt
    endcase
  endfunction

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) data_o <= '0;
    else         data_o <= prog(addr_i);
  end
endmodule

// File: rtl/bfc_tape.sv
module bfc_tape #(
  parameter int DATA_W = 8,
  parameter int AW     = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clr_i,
  input  logic              we_i,
  input  logic [AW-1:0]     addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o
);
  localparam int DEPTH = 1 << AW;

  logic [DATA_W-1:0] mem_q [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_cell
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                          mem_q[g] <= '0;
      else if (clr_i)                       mem_q[g] <= '0;
      else if (we_i && addr_i == AW'(g))    mem_q[g] <= wdata_i;
    end
  end

  // read-before-write, one cycle latency
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rdata_o <= '0;
    else         rdata_o <= mem_q[addr_i];
  end
endmodule

// File: rtl/bfc_ctrl.sv
module bfc_ctrl
  import bfc_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int PC_W   = 4,
  parameter int DP_W   = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              halt_i,
  input  logic [IW-1:0]     rom_i,
  input  logic [DATA_W-1:0] cell_i,
  input  logic              tx_ready_i,
  input  logic              rx_valid_i,
  input  logic [DATA_W-1:0] rx_data_i,
  output logic [PC_W-1:0]   pc_o,
  output logic [DP_W-1:0]   dp_o,
  output logic              clr_o,
  output logic              we_o,
  output logic [DATA_W-1:0] wdata_o,
  output logic              tx_valid_o,
  output logic              rx_ack_o,
  output logic              busy_o
);
  state_e            state_q;
  instr_t            ir_q;
  logic [DATA_W-1:0] alu_q;
  logic [PC_W-1:0]   pc_off;
  logic [DP_W-1:0]   dp_off;
  logic [DATA_W-1:0] amt;
  logic              taken;
  logic              stopped;

  assign pc_off  = PC_W'($signed(ir_q.arg));
  assign dp_off  = DP_W'($signed(ir_q.arg));
  assign amt     = DATA_W'(ir_q.arg);
  assign taken   = (ir_q.op == OP_JZ) ? (cell_i == '0) : (cell_i != '0);
  assign stopped = (state_q == S_IDLE) || (state_q == S_HALTED);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= S_IDLE;
      pc_o    <= '0;
      dp_o    <= '0;
      ir_q    <= '0;
      alu_q   <= '0;
    end else if (halt_i) begin
      state_q <= S_IDLE;
    end else begin
      case (state_q)
        S_IDLE, S_HALTED: if (start_i) begin
          pc_o    <= '0;
          dp_o    <= '0;
          state_q <= S_FETCH;
        end
        S_FETCH: state_q <= S_FWAIT;
        S_FWAIT: begin
          ir_q    <= instr_t'(rom_i);
          state_q <= S_DECODE;
        end
        S_DECODE: begin
          if (ir_q == '0) begin
            state_q <= S_HALTED;
          end else if (ir_q.op == OP_RIGHT) begin
            dp_o    <= dp_o + dp_off;
            pc_o    <= pc_o + PC_W'(1);
            state_q <= S_FETCH;
          end else if (ir_q.op == OP_LEFT) begin
            dp_o    <= dp_o - dp_off;
            pc_o    <= pc_o + PC_W'(1);
            state_q <= S_FETCH;
          end else begin
            state_q <= S_MWAIT;
          end
        end
        S_MWAIT: state_q <= S_EXEC;
        S_EXEC: begin
          case (ir_q.op)
            OP_ADD:  begin alu_q <= cell_i + amt; state_q <= S_WRITE; end
            OP_SUB:  begin alu_q <= cell_i - amt; state_q <= S_WRITE; end
            OP_OUT:  state_q <= S_TXW;
            OP_IN:   state_q <= S_RXW;
            default: state_q <= S_JUMP;
          endcase
        end
        S_WRITE: begin
          pc_o    <= pc_o + PC_W'(1);
          state_q <= S_FETCH;
        end
        S_TXW: if (tx_ready_i) begin
          pc_o    <= pc_o + PC_W'(1);
          state_q <= S_FETCH;
        end
        S_RXW: if (rx_valid_i) begin
          alu_q   <= rx_data_i;
          state_q <= S_WRITE;
        end
        S_JUMP: begin
          pc_o    <= taken ? pc_o + pc_off : pc_o + PC_W'(1);
          state_q <= S_FETCH;
        end
        default: state_q <= S_IDLE;
      endcase
    end
  end

  assign busy_o     = !stopped;
  assign clr_o      = stopped && start_i && !halt_i;
  assign we_o       = (state_q == S_WRITE) && !halt_i;
  assign wdata_o    = alu_q;
  assign tx_valid_o = (state_q == S_TXW) && !halt_i;
  assign rx_ack_o   = we_o && (ir_q.op == OP_IN);
endmodule

// File: rtl/bfc_core.sv
module bfc_core
  import bfc_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int PC_W   = 4,
  parameter int DP_W   = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              halt_i,
  input  logic              tx_ready_i,
  input  logic              rx_valid_i,
  input  logic [DATA_W-1:0] rx_data_i,
  output logic              tx_valid_o,
  output logic [DATA_W-1:0] tx_data_o,
  output logic              rx_ack_o,
  output logic              busy_o,
  output logic [PC_W-1:0]   pc_o,
  output logic [DP_W-1:0]   dp_o,
  output logic [DATA_W-1:0] cell_o
);
  logic [IW-1:0]     rom_q;
  logic [DATA_W-1:0] rd_q;
  logic [DATA_W-1:0] wdata;
  logic              we;
  logic              clr;

  bfc_rom #(.PC_W(PC_W), .IW(IW)) rom_i (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .addr_i (pc_o),
    .data_o (rom_q)
  );

  bfc_tape #(.DATA_W(DATA_W), .AW(DP_W)) tape_i (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clr_i   (clr),
    .we_i    (we),
    .addr_i  (dp_o),
    .wdata_i (wdata),
    .rdata_o (rd_q)
  );

  bfc_ctrl #(.DATA_W(DATA_W), .PC_W(PC_W), .DP_W(DP_W)) ctrl_i (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .start_i    (start_i),
    .halt_i     (halt_i),
    .rom_i      (rom_q),
    .cell_i     (rd_q),
    .tx_ready_i (tx_ready_i),
    .rx_valid_i (rx_valid_i),
    .rx_data_i  (rx_data_i),
    .pc_o       (pc_o),
    .dp_o       (dp_o),
    .clr_o      (clr),
    .we_o       (we),
    .wdata_o    (wdata),
    .tx_valid_o (tx_valid_o),
    .rx_ack_o   (rx_ack_o),
    .busy_o     (busy_o)
  );

  assign tx_data_o = rd_q;
  assign cell_o    = rd_q;
endmodule

// File: rtl/bfc_core_chk.sv
module bfc_core_chk #(
  parameter int DATA_W = 8,
  parameter int PC_W   = 4,
  parameter int DP_W   = 3
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              start_i,
  input logic              halt_i,
  input logic              tx_ready_i,
  input logic              rx_valid_i,
  input logic [DATA_W-1:0] rx_data_i,
  input logic              tx_valid_o,
  input logic [DATA_W-1:0] tx_data_o,
  input logic              rx_ack_o,
  input logic              busy_o,
  input logic [PC_W-1:0]   pc_o,
  input logic [DP_W-1:0]   dp_o,
  input logic [DATA_W-1:0] cell_o
);
  // R9
  halt_stop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    halt_i |=> (!busy_o && pc_o == $past(pc_o)));

  // R3
  start_go_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && start_i && !halt_i) |=> (busy_o && pc_o == '0 && dp_o == '0));

  // R2
  idle_stay_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && !start_i) |=> !busy_o);

  // R5
  tx_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tx_valid_o && !tx_ready_i) |=> ((tx_valid_o || halt_i) && $stable(tx_data_o)));

  // R6
  rx_ack_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_ack_o |=> !rx_ack_o);

  // R6
  rx_ack_after_valid_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_ack_o |-> $past(rx_valid_i));
endmodule

bind bfc_core bfc_core_chk #(.DATA_W(DATA_W), .PC_W(PC_W), .DP_W(DP_W)) chk_i (.*);

// File: tb/bfc_core_tb_top.sv
module bfc_core_tb_top;
  localparam int P_IDLE = 0, P_F = 1, P_FW = 2, P_DEC = 3, P_MW = 4, P_EX = 5,
                 P_WR = 6, P_TX = 7, P_RX = 8, P_JMP = 9, P_HALT = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #5 clk = ~clk;

  logic       start = 1'b0, halt = 1'b0, tx_ready = 1'b0, rx_valid = 1'b0;
  logic [7:0] rx_data = 8'h00;
  logic       tx_valid_o, rx_ack_o, busy_o;
  logic [7:0] tx_data_o, cell_o;
  logic [3:0] pc_o;
  logic [2:0] dp_o;

  bfc_core dut_i (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .halt_i(halt),
    .tx_ready_i(tx_ready), .rx_valid_i(rx_valid), .rx_data_i(rx_data),
    .tx_valid_o(tx_valid_o), .tx_data_o(tx_data_o), .rx_ack_o(rx_ack_o),
    .busy_o(busy_o), .pc_o(pc_o), .dp_o(dp_o), .cell_o(cell_o)
  );

  int n_cmp = 0, n_bad = 0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  // program listing from the requirements
  function automatic int rom_at(input int a);
    case (a)
      0, 9:   return 'hA0;
      1, 11:  return 'h01;
      2:      return 'h4A;
      3:      return 'h21;
      4:      return 'hC6;
      5, 6:   return 'h6F;
      7:      return 'h62;
      8, 12:  return 'h80;
      10:     return 'hFA;
      default: return 0;
    endcase
  endfunction

  function automatic int sx5(input int v);
    return (v & 16) ? v - 32 : v;
  endfunction

  // behavioural reference model
  int m_ph, m_pc, m_dp, m_ir, m_val, m_cell, m_op, m_arg;
  int m_tape [8];

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_ph = P_IDLE; m_pc = 0; m_dp = 0; m_ir = 0; m_val = 0; m_cell = 0;
      foreach (m_tape[i]) m_tape[i] = 0;
    end else begin
      m_cell = m_tape[m_dp];
      m_op = m_ir >> 5;
      m_arg = m_ir & 31;
      if (halt) m_ph = P_IDLE;
      else case (m_ph)
        P_IDLE, P_HALT: if (start) begin
          m_pc = 0; m_dp = 0; m_ph = P_F;
          foreach (m_tape[i]) m_tape[i] = 0;
        end
        P_F:  m_ph = P_FW;
        P_FW: begin m_ir = rom_at(m_pc); m_ph = P_DEC; end
        P_DEC: begin
          if (m_ir == 0) m_ph = P_HALT;
          else if (m_op == 0) begin m_dp = (m_dp + sx5(m_arg)) & 7; m_pc = (m_pc + 1) & 15; m_ph = P_F; end
          else if (m_op == 1) begin m_dp = (m_dp - sx5(m_arg)) & 7; m_pc = (m_pc + 1) & 15; m_ph = P_F; end
          else m_ph = P_MW;
        end
        P_MW: m_ph = P_EX;
        P_EX: begin
          if (m_op == 2)      begin m_val = (m_tape[m_dp] + m_arg) & 255; m_ph = P_WR; end
          else if (m_op == 3) begin m_val = (m_tape[m_dp] - m_arg) & 255; m_ph = P_WR; end
          else if (m_op == 4) m_ph = P_TX;
          else if (m_op == 5) m_ph = P_RX;
          else m_ph = P_JMP;
        end
        P_WR: begin m_tape[m_dp] = m_val; m_pc = (m_pc + 1) & 15; m_ph = P_F; end
        P_TX: if (tx_ready) begin m_pc = (m_pc + 1) & 15; m_ph = P_F; end
        P_RX: if (rx_valid) begin m_val = rx_data; m_ph = P_WR; end
        P_JMP: begin
          if ((m_op == 6) ? (m_tape[m_dp] == 0) : (m_tape[m_dp] != 0))
            m_pc = (m_pc + sx5(m_arg)) & 15;
          else
            m_pc = (m_pc + 1) & 15;
          m_ph = P_F;
        end
        default: m_ph = P_IDLE;
      endcase
    end
  end

  // per-cycle comparison and output collection
  byte out_q[$];
  byte rx_q[$];
  bit  ack_seen = 0;
  int  n_ack = 0;

  always @(negedge clk) begin
    if (rst_n) begin
      bit e_busy, e_txv, e_ack;
      e_busy = !(m_ph == P_IDLE || m_ph == P_HALT);
      e_txv  = (m_ph == P_TX) && !halt;
      e_ack  = (m_ph == P_WR) && ((m_ir >> 5) == 5) && !halt;
      chk(busy_o == e_busy, "R4 busy", busy_o, e_busy);
      chk(int'(pc_o) == m_pc, "R4 pc", pc_o, m_pc);
      chk(int'(dp_o) == m_dp, "R4 dp", dp_o, m_dp);
      chk(int'(cell_o) == m_cell, "R11 cell", cell_o, m_cell);
      chk(tx_valid_o == e_txv, "R5 tx_valid", tx_valid_o, e_txv);
      if (e_txv) chk(int'(tx_data_o) == m_cell, "R5 tx_data", tx_data_o, m_cell);
      chk(rx_ack_o == e_ack, "R6 rx_ack", rx_ack_o, e_ack);
      if (tx_valid_o && tx_ready) out_q.push_back(tx_data_o);
      if (rx_ack_o) begin ack_seen = 1; n_ack++; end
    end
  end

  // serial engine stand-ins
  int cyc = 0, tx_mod = 1, rx_gap = 0;
  bit tx_block = 0, tx_force = 0;

  always @(posedge clk) begin
    #2;
    cyc++;
    tx_ready = tx_force || (!tx_block && (cyc % tx_mod == 0));
    if (ack_seen) begin
      ack_seen = 0; rx_valid = 0; rx_gap = 0;
      void'(rx_q.pop_front());
    end else if (!rx_valid && rx_q.size() > 0) begin
      rx_gap++;
      if (rx_gap >= 4) begin rx_valid = 1; rx_data = rx_q[0]; end
    end
  end

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL watchdog expired");
    summary();
    $finish;
  end

  task automatic pulse_start();
    @(posedge clk); #1 start = 1;
    @(posedge clk); #1 start = 0;
  endtask

  task automatic run_case(input string tag, input byte ins[$], input byte exp[$]);
    int guard;
    out_q.delete();
    n_ack = 0;
    foreach (ins[i]) rx_q.push_back(ins[i]);
    pulse_start();
    guard = 0;
    @(negedge clk);
    while (busy_o && guard < 20000) begin @(negedge clk); guard++; end
    chk(out_q.size() == exp.size(), {tag, " out count"}, out_q.size(), exp.size());
    foreach (exp[i])
      if (i < out_q.size()) chk(out_q[i] == exp[i], {tag, " out byte"}, out_q[i], exp[i]);
    chk(pc_o == 4'd13, "R2 halt pc", pc_o, 13);
    chk(dp_o == 3'd1, "R4 final dp", dp_o, 1);
    chk(cell_o == 8'd10, "R11 final cell", cell_o, 10);
    chk(n_ack == ins.size(), "R6 ack count", n_ack, ins.size());
  endtask

  initial begin
    int pc_hold;
    repeat (3) @(negedge clk);
    // R1 during reset
    chk(busy_o == 0, "R1 busy", busy_o, 0);
    chk(pc_o == 0 && dp_o == 0, "R1 pc/dp", {pc_o, dp_o}, 0);
    chk(cell_o == 0, "R1 cell", cell_o, 0);
    chk(tx_valid_o == 0 && rx_ack_o == 0, "R1 handshake", {tx_valid_o, rx_ack_o}, 0);
    @(posedge clk); #1 rst_n = 1;
    repeat (3) @(negedge clk);
    chk(busy_o == 0, "R1 idle after release", busy_o, 0);

    // R10 main program
    tx_mod = 1;
    run_case("R10", '{8'h61, 8'h62, 8'h63, 8'h00}, '{8'h41, 8'h42, 8'h43, 8'h0A});

    // R8 wrap below zero, slow output engine
    tx_mod = 3;
    run_case("R8", '{8'h10, 8'h7F, 8'h00}, '{8'hF0, 8'h5F, 8'h0A});

    // R7 forward jump taken; R3 newline stays 10 after restart
    run_case("R7", '{8'h00}, '{8'h0A});

    // R9 halt in the same cycle as an output handshake
    tx_block = 1;
    out_q.delete();
    rx_q.push_back(8'h78);
    pulse_start();
    begin
      int g = 0;
      @(negedge clk);
      while (!tx_valid_o && g < 2000) begin @(negedge clk); g++; end
    end
    repeat (3) @(negedge clk);
    chk(tx_valid_o == 1, "R5 tx held", tx_valid_o, 1);
    chk(tx_data_o == 8'h58, "R5 tx value", tx_data_o, 'h58);
    pc_hold = pc_o;
    @(posedge clk); #1 halt = 1; tx_force = 1;
    @(negedge clk);
    chk(tx_valid_o == 0, "R9 tx masked", tx_valid_o, 0);
    @(posedge clk); #1 halt = 0; tx_force = 0;
    @(negedge clk);
    chk(busy_o == 0, "R9 stopped", busy_o, 0);
    chk(int'(pc_o) == pc_hold, "R9 pc kept", pc_o, pc_hold);
    chk(out_q.size() == 0, "R9 no byte", out_q.size(), 0);
    tx_block = 0;

    // R9 start ignored when halt high
    @(posedge clk); #1 start = 1; halt = 1;
    @(posedge clk); #1 start = 0; halt = 0;
    repeat (2) @(negedge clk);
    chk(busy_o == 0, "R9 start masked", busy_o, 0);

    // R3 restart after abort
    tx_mod = 2;
    run_case("R3", '{8'h7A, 8'h00}, '{8'h5A, 8'h0A});

    repeat (5) @(negedge clk);
    summary();
    $finish;
  end
endmodule